// File: doc/BRIEF.md
# Transmit-Failure Flag Register

This block keeps one sticky flag for each transmit slot of a message controller. A flag goes to one when a single-shot transmission in its slot fails. There are two causes of failure, lost arbitration and a transmit error, and each arrives as a one-cycle pulse on its own per-slot input. Software sees the flags through a small register port. A write clears a flag by putting a zero in its bit. A one in a bit leaves that flag as it was, so a clear must carry ones in every position that is to be kept.

A second register, for enables, sits beside the flags and is read and written in the usual way. The block drives one registered interrupt line. The line is high while at least one flag is set and its enable bit is also set. On the data bus the slots are laid out from the top bit down: slot 0 is in bit 15 and slot 15 is in bit 0. A parameter can select the opposite order for other users of the block.

Top module: `txf_status_reg`

## Requirements
- R1: After reset every flag is zero, every enable bit is zero and `irq` is low, so both registers read 0x0000.
- R2: A pulse on `fail_arb[n]` in one cycle sets the flag of slot n from the next cycle on. The flag stays set while no write clears it.
- R3: A pulse on `fail_txerr[n]` sets the flag of slot n in the same way as R2.
- R4: A write with `reg_addr` = 0 (flag register) clears the flag of every slot whose data bit is 0. The change is visible in the cycle after the write.
- R5: In a write to the flag register, a data bit of 1 leaves the flag of its slot unchanged, whether that flag is set or clear.
- R6: When a failure pulse and a zero-write reach the same slot in the same cycle, the flag ends up set.
- R7: Slot n sits at data bit 15-n in both registers, on reads and on writes.
- R8: A write with `reg_addr` = 1 stores the data into the enable register. A read with `reg_addr` = 1 returns the enables, and a read with `reg_addr` = 0 returns the flags.
- R9: `irq` is the OR over all slots of (flag AND enable), taken one clock after the flags and enables hold those values. A flag whose enable bit is zero never raises `irq`.
- R10: `irq` falls one cycle after the last enabled flag is cleared, or after its enable bit is written to zero.
- R11: Reading either register, or changing `reg_addr`, does not change any flag, any enable bit or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fail_arb | input | 16 | Per-slot pulse: arbitration lost (bit n = slot n) |
| fail_txerr | input | 16 | Per-slot pulse: transmit error (bit n = slot n) |
| reg_addr | input | 1 | Register select: 0 flags, 1 enables |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 16 | Write data, slot n at bit 15-n |
| rd_data | output | 16 | Selected register, slot n at bit 15-n |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the failure inputs and the write signals are stable across each rising edge, and that `reg_addr` is only ever 0 or 1. They make no assumption that pulses last a single cycle. The bench drives every input on the falling edge and reads on the following falling edge, so each value it checks comes after exactly one register update. Collisions are produced on purpose by raising a failure pulse and a write strobe on the same falling edge.

// File: rtl/txf_pkg.sv
package txf_pkg;
   typedef enum logic {
      SEL_FLAGS  = 1'b0,
      SEL_ENABLE = 1'b1
   } txf_sel_e;

   // bus position of a slot for a given layout
   function automatic int slot_pos(input int slot, input int bus_w, input bit msb_first);
      return msb_first ? (bus_w - 1 - slot) : slot;
   endfunction
endpackage

// File: rtl/txf_bus_to_slot.sv
module txf_bus_to_slot #(
   parameter int SLOTS     = 16,
   parameter int BUS_W     = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic [BUS_W-1:0] bus_in,
   output logic [SLOTS-1:0] slot_out
);
   import txf_pkg::*;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      localparam int POS = slot_pos(i, BUS_W, MSB_FIRST);
      assign slot_out[i] = bus_in[POS];
   end
endmodule

// File: rtl/txf_slot_to_bus.sv
module txf_slot_to_bus #(
   parameter int SLOTS     = 16,
   parameter int BUS_W     = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic [SLOTS-1:0] slot_in,
   output logic [BUS_W-1:0] bus_out
);
   import txf_pkg::*;

   always_comb begin
      bus_out = '0;
      for (int i = 0; i < SLOTS; i++) begin
         bus_out[slot_pos(i, BUS_W, MSB_FIRST)] = slot_in[i];
      end
   end
endmodule

// File: rtl/txf_flag_cell.sv
module txf_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   // set has priority over clear so a failure is never lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/txf_irq_merge.sv
module txf_irq_merge #(
   parameter int SLOTS      = 16,
   parameter bit REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SLOTS-1:0] flags,
   input  logic [SLOTS-1:0] enables,
   output logic             irq
);
   logic pending;
   assign pending = |(flags & enables);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= pending;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq = pending;
   end
endmodule

// File: rtl/txf_status_reg.sv
module txf_status_reg #(
   parameter int SLOTS     = 16,
   parameter int BUS_W     = 16,
   parameter bit MSB_FIRST = 1'b1,
   parameter bit IRQ_REG   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SLOTS-1:0] fail_arb,
   input  logic [SLOTS-1:0] fail_txerr,
   input  logic             reg_addr,
   input  logic             wr_en,
   input  logic [BUS_W-1:0] wr_data,
   output logic [BUS_W-1:0] rd_data,
   output logic             irq
);
   import txf_pkg::*;

   if (SLOTS < 1 || SLOTS > BUS_W) begin : g_bad_slots
      $error("txf_status_reg: SLOTS must be in 1..BUS_W");
   end

   logic [SLOTS-1:0] flag_q;
   logic [SLOTS-1:0] en_q;
   logic [SLOTS-1:0] wr_slot;
   logic [SLOTS-1:0] fail_any;
   logic [BUS_W-1:0] flag_bus;
   logic [BUS_W-1:0] en_bus;
   logic             wr_flags;
   logic             wr_enable;

   assign fail_any  = fail_arb | fail_txerr;
   assign wr_flags  = wr_en && (txf_sel_e'(reg_addr) == SEL_FLAGS);
   assign wr_enable = wr_en && (txf_sel_e'(reg_addr) == SEL_ENABLE);

   txf_bus_to_slot #(.SLOTS(SLOTS), .BUS_W(BUS_W), .MSB_FIRST(MSB_FIRST)) u_wr_map (
      .bus_in  (wr_data),
      .slot_out(wr_slot)
   );

   for (genvar i = 0; i < SLOTS; i++) begin : g_flag
      txf_flag_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (fail_any[i]),
         .clr_i (wr_flags && !wr_slot[i]),
         .flag_o(flag_q[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= '0;
      else if (wr_enable) en_q <= wr_slot;
   end

   txf_slot_to_bus #(.SLOTS(SLOTS), .BUS_W(BUS_W), .MSB_FIRST(MSB_FIRST)) u_flag_map (
      .slot_in(flag_q),
      .bus_out(flag_bus)
   );

   txf_slot_to_bus #(.SLOTS(SLOTS), .BUS_W(BUS_W), .MSB_FIRST(MSB_FIRST)) u_en_map (
      .slot_in(en_q),
      .bus_out(en_bus)
   );

   assign rd_data = (txf_sel_e'(reg_addr) == SEL_FLAGS) ? flag_bus : en_bus;

   txf_irq_merge #(.SLOTS(SLOTS), .REGISTERED(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .flags  (flag_q),
      .enables(en_q),
      .irq    (irq)
   );
endmodule

// File: rtl/txf_status_reg_chk.sv
module txf_status_reg_chk #(
   parameter int SLOTS     = 16,
   parameter int BUS_W     = 16,
   parameter bit MSB_FIRST = 1'b1,
   parameter bit IRQ_REG   = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SLOTS-1:0] fail_arb,
   input logic [SLOTS-1:0] fail_txerr,
   input logic             reg_addr,
   input logic             wr_en,
   input logic [BUS_W-1:0] wr_data,
   input logic [SLOTS-1:0] flags,
   input logic [SLOTS-1:0] enables,
   input logic             irq
);
   function automatic logic [SLOTS-1:0] keep_mask(input logic [BUS_W-1:0] d);
      logic [SLOTS-1:0] m;
      for (int i = 0; i < SLOTS; i++) m[i] = d[MSB_FIRST ? BUS_W-1-i : i];
      return m;
   endfunction

   logic [SLOTS-1:0] ev;
   assign ev = fail_arb | fail_txerr;

   // R2 / R3: every failure pulse leaves its flag set
   assert_fail_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev) |=> ((flags & $past(ev)) == $past(ev)));

   // R2: no flag rises without a failure pulse
   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & ~$past(flags) & ~$past(ev)) == '0));

   // R2: flags are sticky while the flag register is not written
   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && reg_addr == 1'b0) |=> ((flags & $past(flags)) == $past(flags)));

   // R4 / R5 / R6: zero clears, one keeps, set wins
   assert_zero_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr == 1'b0) |=>
         (flags == (($past(flags) & keep_mask($past(wr_data))) | $past(ev))));

   // R8: enable write stores the data
   assert_enable_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr == 1'b1) |=> (enables == keep_mask($past(wr_data))));

   if (IRQ_REG) begin : g_irq_chk
      // R9 / R10: registered OR of flag AND enable
      assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == |($past(flags) & $past(enables))));
   end
endmodule

bind txf_status_reg txf_status_reg_chk #(
   .SLOTS(SLOTS), .BUS_W(BUS_W), .MSB_FIRST(MSB_FIRST), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fail_arb  (fail_arb),
   .fail_txerr(fail_txerr),
   .reg_addr  (reg_addr),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .flags     (flag_q),
   .enables   (en_q),
   .irq       (irq)
);

// File: tb/txf_status_reg_tb.sv
module txf_status_reg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] fail_arb = '0;
   logic [15:0] fail_txerr = '0;
   logic        reg_addr = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   txf_status_reg u_dut (
      .clk(clk), .rst_n(rst_n), .fail_arb(fail_arb), .fail_txerr(fail_txerr),
      .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .irq(irq)
   );

   function automatic logic [15:0] sbit(input int n);
      return 16'h8000 >> n;
   endfunction

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic rd(input logic a, output logic [15:0] v);
      reg_addr = a;
      #1 v = rd_data;
   endtask

   task automatic wr(input logic a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [15:0] arb, input logic [15:0] txe);
      @(negedge clk);
      fail_arb = arb; fail_txerr = txe;
      @(negedge clk);
      fail_arb = '0; fail_txerr = '0;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      rd(1'b0, v); check("R1 flags", v, 16'h0000);
      rd(1'b1, v); check("R1 enables", v, 16'h0000);
      check("R1 irq", {15'b0, irq}, 16'h0000);
   endtask

   task automatic t_arb();
      logic [15:0] v;
      pulse(16'h0008, 16'h0000);           // slot 3
      rd(1'b0, v); check("R2 R7 arb slot3", v, sbit(3));
      repeat (3) @(negedge clk);
      rd(1'b0, v); check("R2 sticky", v, sbit(3));
   endtask

   task automatic t_txerr();
      logic [15:0] v;
      pulse(16'h0000, 16'h0001);           // slot 0
      rd(1'b0, v); check("R3 R7 txerr slot0", v, sbit(3) | sbit(0));
   endtask

   task automatic t_clear();
      logic [15:0] v;
      wr(1'b0, ~sbit(3));
      rd(1'b0, v); check("R4 clear slot3", v, sbit(0));
      wr(1'b0, 16'hFFFF);
      rd(1'b0, v); check("R5 ones keep", v, sbit(0));
      wr(1'b0, 16'h0000);
      rd(1'b0, v); check("R4 clear all", v, 16'h0000);
   endtask

   task automatic t_collide();
      logic [15:0] v;
      pulse(16'h0000, 16'h0020);           // slot 5 set first
      @(negedge clk);
      reg_addr = 1'b0; wr_data = 16'h0000; wr_en = 1'b1;
      fail_arb = 16'h0080;                 // slot 7 event during clear-all
      @(negedge clk);
      wr_en = 1'b0; fail_arb = '0;
      rd(1'b0, v); check("R6 set wins", v, sbit(7));
      wr(1'b0, 16'h0000);
   endtask

   task automatic t_enable();
      logic [15:0] v;
      wr(1'b1, 16'hA5C3);
      rd(1'b1, v); check("R8 enable readback", v, 16'hA5C3);
      rd(1'b0, v); check("R8 flag view", v, 16'h0000);
      check("R9 no flags no irq", {15'b0, irq}, 16'h0000);
   endtask

   task automatic t_irq();
      logic [15:0] v;
      wr(1'b1, sbit(9));
      pulse(16'h0004, 16'h0000);           // slot 2, not enabled
      @(negedge clk);
      check("R9 masked slot", {15'b0, irq}, 16'h0000);
      pulse(16'h0200, 16'h0000);           // slot 9, enabled
      check("R9 irq one cycle late", {15'b0, irq}, 16'h0000);
      @(negedge clk);
      check("R9 irq high", {15'b0, irq}, 16'h0001);
      wr(1'b0, ~sbit(9));
      check("R10 irq still high", {15'b0, irq}, 16'h0001);
      @(negedge clk);
      check("R10 irq drops on clear", {15'b0, irq}, 16'h0000);
      rd(1'b0, v); check("R10 slot2 kept", v, sbit(2));
      pulse(16'h0200, 16'h0000);
      @(negedge clk);
      check("R9 irq again", {15'b0, irq}, 16'h0001);
      wr(1'b1, 16'h0000);
      @(negedge clk);
      check("R10 irq drops on disable", {15'b0, irq}, 16'h0000);
   endtask

   task automatic t_read_only();
      logic [15:0] a, b;
      rd(1'b0, a);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         reg_addr = k[0];
      end
      @(negedge clk);
      rd(1'b0, b); check("R11 flags unchanged", b, a);
      rd(1'b1, b); check("R11 enables unchanged", b, 16'h0000);
   endtask

   initial begin
      #100_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_arb();
      t_txerr();
      t_clear();
      t_collide();
      t_enable();
      t_irq();
      t_read_only();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule